// File: doc/BRIEF.md
# Loop-Disconnect Pulse Dialer

This block turns a dialed digit into a loop-disconnect pulse train on a line-control output. The output rests high (line made) and drops low for each break. Pulses repeat at 10 pulses per second. A pin selects the make/break ratio, either 40/60 or 33/67. For the whole of a pulse transmission, including the inter-digit pause that follows it, an active-low speech-mute output is driven low.

Digits arrive on a valid/ready stream. A digit is taken on any clock edge where `dig_valid_i` and `dig_ready_o` are both high. While a pulse-mode digit is being sent, `dig_ready_o` is low. An upstream source that holds `dig_valid_i` high during that time is simply back-pressured: it must keep its digit stable until ready returns, and nothing is taken in the meantime.

The dialing mode and the ratio are read only at the moment a digit is accepted. If either pin changes in the middle of a digit, that digit is unaffected and the new setting applies from the next digit. In tone mode the line output never moves.

All timing comes from a tick of `TICK_CYCLES` clocks, which stands for 1 ms. With the default parameters one pulse lasts 100 ticks.

Top module: `pulse_dialer`

## Requirements
- R1: A digit is accepted on a clock edge where `dig_valid_i` and `dig_ready_o` are both high. After a pulse-mode accept, `dig_ready_o` is low for exactly N·PERIOD_TICKS·TICK_CYCLES + PAUSE_TICKS·TICK_CYCLES cycles, where N is the break count. While `dig_ready_o` is low, `dig_valid_i` is ignored, and nothing is accepted on the edge that ends the busy period.
- R2: `dig_code_i` is binary. Codes 1 to 9 give that number of breaks, and code 0 gives 10 breaks.
- R3: Each break holds `line_o` low for (PERIOD_TICKS − make ticks)·TICK_CYCLES consecutive cycles. The first break starts in the cycle right after the accept.
- R4: `ratio_hi_i` high selects MAKE_HI_TICKS (40) make ticks per pulse, and low selects MAKE_LO_TICKS (33). The make interval between two breaks lasts make ticks·TICK_CYCLES cycles.
- R5: After the last break, `line_o` stays high for (make ticks + PAUSE_TICKS)·TICK_CYCLES cycles before `dig_ready_o` rises.
- R6: `mute_n_o` is low in every cycle where `dig_ready_o` is low, and high whenever the block is idle.
- R7: With `pulse_mode_i` low (tone mode), an accepted digit causes no break: `line_o` and `mute_n_o` stay high and `dig_ready_o` stays high.
- R8: Changes on `pulse_mode_i` or `ratio_hi_i` after a digit is accepted do not alter that digit's pulse train. The next digit uses the new values.
- R9: Codes 10 to 15 are accepted and discarded in either mode: no break occurs and `dig_ready_o` stays high.
- R10: During synchronous active-low reset, `line_o`, `mute_n_o` and `dig_ready_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dig_valid_i | input | 1 | Digit valid |
| dig_ready_o | output | 1 | Block idle and able to take a digit |
| dig_code_i | input | 4 | Binary digit code |
| pulse_mode_i | input | 1 | 1 = pulse dialing, 0 = tone mode |
| ratio_hi_i | input | 1 | 1 = 40/60 make/break, 0 = 33/67 |
| line_o | output | 1 | Line control: high = make, low = break |
| mute_n_o | output | 1 | Speech mute, active low |

## Verification
The bench builds the block with TICK_CYCLES = 3 and PAUSE_TICKS = 25, and keeps the real tick counts of 100, 40 and 33 per pulse. A non-unit prescaler is therefore exercised, and every break, make and pause length can be checked to the exact cycle. A ten-break digit still completes in about 3,100 cycles, so dozens of random digits fit in the run, covering both ratios, mode and ratio flips mid-digit, invalid codes and held valid.

// File: rtl/pd_pkg.sv
package pd_pkg;

  typedef enum logic [1:0] {
    PD_IDLE  = 2'd0,
    PD_BREAK = 2'd1,
    PD_MAKE  = 2'd2,
    PD_PAUSE = 2'd3
  } pd_state_t;

  // code 0 dials ten breaks, 1..9 dial their own value
  function automatic logic [3:0] pd_break_count(input logic [3:0] code);
    return (code == 4'd0) ? 4'd10 : code;
  endfunction

  function automatic logic pd_code_ok(input logic [3:0] code);
    return code <= 4'd9;
  endfunction

endpackage

// File: rtl/pd_interval_timer.sv
module pd_interval_timer #(
  parameter int TICK_CYCLES = 100000,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             run_i,
  output logic             done_o
);

  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

  logic [CNT_W-1:0] rem_q;
  logic             tick;

  generate
    if (TICK_CYCLES > 1) begin : g_pre
      logic [PW-1:0] pre_q;
      assign tick = (pre_q == PW'(TICK_CYCLES - 1));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pre_q <= '0;
        end else if (load_i || tick) begin
          pre_q <= '0;
        end else if (run_i) begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (load_i) begin
      rem_q <= len_i;
    end else if (run_i && tick && rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  assign done_o = run_i && tick && (rem_q == CNT_W'(1));

endmodule

// File: rtl/pd_ratio_sel.sv
module pd_ratio_sel #(
  parameter int PERIOD_TICKS  = 100,
  parameter int MAKE_HI_TICKS = 40,
  parameter int MAKE_LO_TICKS = 33,
  parameter int CNT_W         = 8
) (
  input  logic             ratio_hi_i,
  output logic [CNT_W-1:0] make_len_o,
  output logic [CNT_W-1:0] break_len_o
);

  localparam logic [CNT_W-1:0] MK_HI = CNT_W'(MAKE_HI_TICKS);
  localparam logic [CNT_W-1:0] MK_LO = CNT_W'(MAKE_LO_TICKS);
  localparam logic [CNT_W-1:0] BR_HI = CNT_W'(PERIOD_TICKS - MAKE_HI_TICKS);
  localparam logic [CNT_W-1:0] BR_LO = CNT_W'(PERIOD_TICKS - MAKE_LO_TICKS);

  assign make_len_o  = ratio_hi_i ? MK_HI : MK_LO;
  assign break_len_o = ratio_hi_i ? BR_HI : BR_LO;

endmodule

// File: rtl/pd_seq.sv
module pd_seq
  import pd_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PAUSE_TICKS = 800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  input  logic [3:0]       code_i,
  input  logic             pulse_mode_i,
  input  logic             ratio_hi_i,
  output logic             sel_ratio_o,
  input  logic [CNT_W-1:0] make_len_i,
  input  logic [CNT_W-1:0] break_len_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_len_o,
  output logic             tmr_run_o,
  input  logic             tmr_done_i,
  output pd_state_t        state_o
);

  pd_state_t  state_q, state_d;
  logic [3:0] left_q, left_d;
  logic       ratio_q, ratio_d;
  logic       start;

  assign start = in_valid_i && (state_q == PD_IDLE) && pulse_mode_i && pd_code_ok(code_i);

  // lengths come from the live pin while idle, from the latched ratio afterwards
  assign sel_ratio_o = (state_q == PD_IDLE) ? ratio_hi_i : ratio_q;

  always_comb begin
    state_d    = state_q;
    left_d     = left_q;
    ratio_d    = ratio_q;
    tmr_load_o = 1'b0;
    tmr_len_o  = '0;
    unique case (state_q)
      PD_IDLE: begin
        if (start) begin
          state_d    = PD_BREAK;
          left_d     = pd_break_count(code_i);
          ratio_d    = ratio_hi_i;
          tmr_load_o = 1'b1;
          tmr_len_o  = break_len_i;
        end
      end
      PD_BREAK: begin
        if (tmr_done_i) begin
          state_d    = PD_MAKE;
          tmr_load_o = 1'b1;
          tmr_len_o  = make_len_i;
        end
      end
      PD_MAKE: begin
        if (tmr_done_i) begin
          tmr_load_o = 1'b1;
          if (left_q == 4'd1) begin
            state_d   = PD_PAUSE;
            tmr_len_o = CNT_W'(PAUSE_TICKS);
          end else begin
            state_d   = PD_BREAK;
            left_d    = left_q - 4'd1;
            tmr_len_o = break_len_i;
          end
        end
      end
      PD_PAUSE: begin
        if (tmr_done_i) begin
          state_d = PD_IDLE;
        end
      end
      default: state_d = PD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PD_IDLE;
      left_q  <= '0;
      ratio_q <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      ratio_q <= ratio_d;
    end
  end

  assign tmr_run_o = (state_q != PD_IDLE);
  assign state_o   = state_q;

endmodule

// File: rtl/pulse_dialer.sv
module pulse_dialer
  import pd_pkg::*;
#(
  parameter int TICK_CYCLES   = 100000,
  parameter int PERIOD_TICKS  = 100,
  parameter int MAKE_HI_TICKS = 40,
  parameter int MAKE_LO_TICKS = 33,
  parameter int PAUSE_TICKS   = 800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dig_valid_i,
  output logic       dig_ready_o,
  input  logic [3:0] dig_code_i,
  input  logic       pulse_mode_i,
  input  logic       ratio_hi_i,
  output logic       line_o,
  output logic       mute_n_o
);

  localparam int MAX_LEN = (PERIOD_TICKS > PAUSE_TICKS) ? PERIOD_TICKS : PAUSE_TICKS;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic             sel_ratio;
  logic [CNT_W-1:0] make_len, break_len, tmr_len;
  logic             tmr_load, tmr_run, tmr_done;
  pd_state_t        state;

  pd_ratio_sel #(
    .PERIOD_TICKS (PERIOD_TICKS),
    .MAKE_HI_TICKS(MAKE_HI_TICKS),
    .MAKE_LO_TICKS(MAKE_LO_TICKS),
    .CNT_W        (CNT_W)
  ) u_ratio (
    .ratio_hi_i (sel_ratio),
    .make_len_o (make_len),
    .break_len_o(break_len)
  );

  pd_seq #(
    .CNT_W      (CNT_W),
    .PAUSE_TICKS(PAUSE_TICKS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (dig_valid_i),
    .code_i      (dig_code_i),
    .pulse_mode_i(pulse_mode_i),
    .ratio_hi_i  (ratio_hi_i),
    .sel_ratio_o (sel_ratio),
    .make_len_i  (make_len),
    .break_len_i (break_len),
    .tmr_load_o  (tmr_load),
    .tmr_len_o   (tmr_len),
    .tmr_run_o   (tmr_run),
    .tmr_done_i  (tmr_done),
    .state_o     (state)
  );

  pd_interval_timer #(
    .TICK_CYCLES(TICK_CYCLES),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(tmr_load),
    .len_i (tmr_len),
    .run_i (tmr_run),
    .done_o(tmr_done)
  );

  // outputs decode straight from the state register
  assign dig_ready_o = (state == PD_IDLE);
  assign mute_n_o    = (state == PD_IDLE);
  assign line_o      = (state != PD_BREAK);

endmodule

// File: rtl/pulse_dialer_chk.sv
module pulse_dialer_chk #(
  parameter int TICK_CYCLES   = 100000,
  parameter int PERIOD_TICKS  = 100,
  parameter int MAKE_HI_TICKS = 40,
  parameter int MAKE_LO_TICKS = 33
) (
  input logic       clk,
  input logic       rst_n,
  input logic       dig_valid_i,
  input logic       dig_ready_o,
  input logic [3:0] dig_code_i,
  input logic       pulse_mode_i,
  input logic       ratio_hi_i,
  input logic       line_o,
  input logic       mute_n_o
);

  int unsigned low_cnt;
  int unsigned brk_exp;
  logic        acc;

  assign acc = dig_valid_i && dig_ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt <= 0;
      brk_exp <= 0;
    end else begin
      low_cnt <= line_o ? 0 : low_cnt + 1;
      if (acc && pulse_mode_i && dig_code_i <= 4'd9)
        brk_exp <= (ratio_hi_i ? (PERIOD_TICKS - MAKE_HI_TICKS) : (PERIOD_TICKS - MAKE_LO_TICKS)) * TICK_CYCLES;
    end
  end

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pulse_mode_i && dig_code_i <= 4'd9) |=> (!dig_ready_o && !line_o)); // R1
  AST_LOW_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !line_o |-> !mute_n_o); // R6
  AST_BREAK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_o) |-> (low_cnt == brk_exp)); // R3
  AST_TONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !pulse_mode_i) |=> (dig_ready_o && line_o && mute_n_o)); // R7
  AST_BAD_CODE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dig_code_i > 4'd9) |=> (dig_ready_o && line_o)); // R9
  AST_BUSY_HOLDS_LINE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dig_ready_o && $past(!dig_ready_o) && !line_o && $past(line_o)) |-> $past(!mute_n_o)); // R6

endmodule

bind pulse_dialer pulse_dialer_chk #(
  .TICK_CYCLES  (TICK_CYCLES),
  .PERIOD_TICKS (PERIOD_TICKS),
  .MAKE_HI_TICKS(MAKE_HI_TICKS),
  .MAKE_LO_TICKS(MAKE_LO_TICKS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dig_valid_i (dig_valid_i),
  .dig_ready_o (dig_ready_o),
  .dig_code_i  (dig_code_i),
  .pulse_mode_i(pulse_mode_i),
  .ratio_hi_i  (ratio_hi_i),
  .line_o      (line_o),
  .mute_n_o    (mute_n_o)
);

// File: tb/pulse_dialer_bench.sv
module pulse_dialer_bench;

  localparam int TC  = 3;
  localparam int PER = 100;
  localparam int MHI = 40;
  localparam int MLO = 33;
  localparam int PSE = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dig_valid_i = 1'b0;
  logic       dig_ready_o;
  logic [3:0] dig_code_i = 4'd0;
  logic       pulse_mode_i = 1'b1;
  logic       ratio_hi_i = 1'b1;
  logic       line_o;
  logic       mute_n_o;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  pulse_dialer #(
    .TICK_CYCLES  (TC),
    .PERIOD_TICKS (PER),
    .MAKE_HI_TICKS(MHI),
    .MAKE_LO_TICKS(MLO),
    .PAUSE_TICKS  (PSE)
  ) u_pulse_dialer (
    .clk         (clk),
    .rst_n       (rst_n),
    .dig_valid_i (dig_valid_i),
    .dig_ready_o (dig_ready_o),
    .dig_code_i  (dig_code_i),
    .pulse_mode_i(pulse_mode_i),
    .ratio_hi_i  (ratio_hi_i),
    .line_o      (line_o),
    .mute_n_o    (mute_n_o)
  );

  function automatic int exp_breaks(input int d);
    return (d == 0) ? 10 : d;
  endfunction
  function automatic int exp_make(input bit r);
    return (r ? MHI : MLO) * TC;
  endfunction
  function automatic int exp_brk(input bit r);
    return (PER - (r ? MHI : MLO)) * TC;
  endfunction
  function automatic int exp_busy(input int d, input bit r);
    return exp_breaks(d) * PER * TC + PSE * TC;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic run_digit(input int d, input bit m, input bit r, input bit flip, input bit press);
    int busy, brks, lowrun, highrun, bad_low, bad_high, mute_bad;
    bit prev;
    @(negedge clk);
    dig_code_i = 4'(d); pulse_mode_i = m; ratio_hi_i = r; dig_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (press) dig_code_i = 4'd7; else dig_valid_i = 1'b0;
    if (flip) begin pulse_mode_i = !m; ratio_hi_i = !r; end
    if (!m || d > 9) begin
      dig_valid_i = 1'b0;
      for (int i = 0; i < 4; i++) begin
        if (d > 9) begin
          chk(dig_ready_o && line_o && mute_n_o, "R9 code dropped", {dig_ready_o, line_o, mute_n_o}, 7);
        end else begin
          chk(dig_ready_o && line_o && mute_n_o, "R7 tone quiet", {dig_ready_o, line_o, mute_n_o}, 7);
        end
        @(negedge clk);
      end
      return;
    end
    busy = 0; brks = 0; lowrun = 0; highrun = 0; bad_low = 0; bad_high = 0; mute_bad = 0;
    prev = 1'b1;
    while (!dig_ready_o && busy < 40000) begin
      busy++;
      if (mute_n_o) mute_bad++;
      if (!line_o) begin
        if (prev) begin
          brks++;
          if (brks > 1 && highrun != exp_make(r)) bad_high++;
        end
        lowrun++;
        highrun = 0;
      end else begin
        if (!prev) begin
          if (lowrun != exp_brk(r)) bad_low++;
          lowrun = 0;
        end
        highrun++;
      end
      prev = line_o;
      @(negedge clk);
    end
    dig_valid_i = 1'b0;
    chk(busy == exp_busy(d, r), "R1 busy length", busy, exp_busy(d, r));
    chk(brks == exp_breaks(d), "R2 break count", brks, exp_breaks(d));
    chk(bad_low == 0, "R3 break width", bad_low, 0);
    chk(bad_high == 0, "R4 make width", bad_high, 0);
    chk(highrun == exp_make(r) + PSE * TC, "R5 final make plus pause", highrun, exp_make(r) + PSE * TC);
    chk(mute_bad == 0 && mute_n_o, "R6 mute during busy", mute_bad, 0);
    if (flip) chk(brks == exp_breaks(d) && bad_low == 0, "R8 flip mid digit", brks, exp_breaks(d));
    if (press) begin
      @(negedge clk);
      chk(dig_ready_o && line_o, "R1 held valid not taken", dig_ready_o, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(line_o && mute_n_o && dig_ready_o, "R10 reset state", {line_o, mute_n_o, dig_ready_o}, 7);
    rst_n = 1'b1;
    @(negedge clk);
    run_digit(1, 1'b1, 1'b1, 1'b0, 1'b0);
    run_digit(0, 1'b1, 1'b0, 1'b0, 1'b1);
    run_digit(9, 1'b1, 1'b1, 1'b1, 1'b0);
    run_digit(5, 1'b0, 1'b1, 1'b0, 1'b0);
    run_digit(3, 1'b1, 1'b0, 1'b0, 1'b0);
    run_digit(12, 1'b1, 1'b0, 1'b0, 1'b0);
    run_digit(15, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 28; k++) begin
      int d;
      bit m, r, f, p;
      d = int'($urandom % 16);
      m = ($urandom % 4) != 0;
      r = $urandom % 2;
      f = $urandom % 2;
      p = $urandom % 2;
      run_digit(d, m, r, f, p);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule